// File: doc/BRIEF.md
# Clustered multi-segment PWM generator

This block is a high-resolution pulse-width modulator that runs from one fast clock. It does not make a single long pulse per frame. It divides every frame of 2^CNT_W clocks into N = 2^SEG_LOG2 equal sub-periods. Each sub-period carries one high pulse that starts on its first clock. The resolution is that of a 2^CNT_W-step PWM, but the ripple that a downstream low-pass filter has to remove sits N times higher in frequency. The filter can therefore be N times wider for the same residual ripple, and it adds less delay.

Each pulse is the duty word divided by N, rounded down. The remainder of that division is spread one clock at a time over the sub-periods. A sub-period gets the extra clock when its index, with the bits in reverse order, is smaller than the remainder. This places the longer pulses far apart in the frame. The pattern is a pure function of the duty word, so there is no dither noise. Each frame also has a fixed number of edges, so an asymmetry between the rising and falling edges of an isolator becomes an offset and not a non-linearity.

The duty word is taken in only on the last clock of a frame, so no frame ever mixes two settings. Two strobes mark the start of each frame and the start of each sub-period for the logic around the block.

Top module: `clustered_pwm`

## Requirements
- R1: A synchronous reset clears the timing counter and the captured duty value. While reset is held, pwm_out, frame_start and subperiod_start are low. In the first clock after reset is released, frame_start is high. The frame that begins there is entirely low, whatever duty_in is.
- R2: A frame lasts exactly 2^CNT_W clocks. frame_start is high for exactly one clock, the first clock of each frame.
- R3: subperiod_start is high for one clock at the first clock of each sub-period. There are N per frame, 2^(CNT_W-SEG_LOG2) clocks apart, and one of them coincides with frame_start.
- R4: Within each sub-period the output is one contiguous run of high clocks that starts on the sub-period's first clock. After the run the output is low up to the sub-period's end. A run of zero length leaves the sub-period entirely low.
- R5: Sub-period number s (0 first in the frame, s taken from the top SEG_LOG2 bits of the position in the frame) is high for floor(D/N) clocks. It gets one more clock when rev(s) < D mod N. Here rev(s) swaps bit b of s with bit SEG_LOG2-1-b. With N=4 and D mod 4 = 2, this extends sub-periods 0 and 2.
- R6: The total number of high clocks in a frame equals the captured duty word D.
- R7: D is the value of duty_in on the last clock of the previous frame. Changes to duty_in at any other time have no effect on the frame in progress.
- R8: With D = 0 the output stays low for the whole frame.
- R9: With D = 2^CNT_W - 1 the output is high on every clock of the frame except the last one, and the value never wraps to a short pulse.
- R10: For N <= D < 2^CNT_W - N, each frame contains exactly N rising edges of pwm_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | CNT_W | Requested number of high clocks per frame, captured at the frame boundary |
| pwm_out | output | 1 | Clustered PWM output |
| frame_start | output | 1 | One-clock strobe on the first clock of each frame |
| subperiod_start | output | 1 | One-clock strobe on the first clock of each sub-period |

## Verification
Two cases are hard to bring about from the ports. The first is a change of duty_in that falls inside a frame, while the frame's output must still follow the old value. The second is the rounding boundary where the remainder selects which sub-periods grow. The bench uses an 8-bit counter with four sub-periods, so one frame is 256 clocks. It sweeps every duty value in turn. In each measured frame it first drives duty_in to an unrelated value and then to the next setting halfway through. Each frame is checked against the widths predicted for the value captured at the frame before. The sweep covers all remainder patterns, the all-low and all-high ends, and the jumps between them. A reset in the middle of a frame shows that the restart is clean.

// File: rtl/pwm_cluster_pkg.sv
package pwm_cluster_pkg;

   // Allowed range for the log2 of the sub-period count (4 or 8 sub-periods).
   localparam int SEG_LOG2_MIN = 2;
   localparam int SEG_LOG2_MAX = 3;

   // Smallest position field that still leaves room for a pulse and a gap.
   localparam int POS_W_MIN = 2;

   function automatic int seg_count(input int log2n);
      return 1 << log2n;
   endfunction

endpackage

// File: rtl/cpwm_timebase.sv
// Free-running frame counter split into sub-period index and in-segment position.
module cpwm_timebase #(
   parameter int CNT_W    = 20,
   parameter int SEG_LOG2 = 2,
   localparam int POS_W   = CNT_W - SEG_LOG2
) (
   input  logic                clk,
   input  logic                rst,
   output logic [SEG_LOG2-1:0] seg_idx_o,
   output logic [POS_W-1:0]    seg_pos_o,
   output logic                frame_first_o,
   output logic                frame_last_o,
   output logic                seg_first_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign seg_idx_o     = cnt_q[CNT_W-1 -: SEG_LOG2];
   assign seg_pos_o     = cnt_q[POS_W-1:0];
   assign frame_first_o = (cnt_q == '0);
   assign frame_last_o  = &cnt_q;
   assign seg_first_o   = (seg_pos_o == '0);

endmodule

// File: rtl/cpwm_duty_split.sv
// Captures the duty word at the frame boundary and splits it into base width and remainder.
module cpwm_duty_split #(
   parameter int CNT_W    = 20,
   parameter int SEG_LOG2 = 2,
   localparam int POS_W   = CNT_W - SEG_LOG2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_i,
   input  logic [CNT_W-1:0]    duty_i,
   output logic [CNT_W-1:0]    duty_q_o,
   output logic [POS_W-1:0]    base_o,
   output logic [SEG_LOG2-1:0] rem_o
);

   logic [CNT_W-1:0] duty_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         duty_q <= '0;
      end else if (load_i) begin
         duty_q <= duty_i;
      end
   end

   // Division by a power of two is a plain bit split.
   assign base_o   = duty_q[CNT_W-1:SEG_LOG2];
   assign rem_o    = duty_q[SEG_LOG2-1:0];
   assign duty_q_o = duty_q;

endmodule

// File: rtl/cpwm_seg_shaper.sv
// Decides the output level from the position in the frame and the split duty value.
module cpwm_seg_shaper #(
   parameter int CNT_W    = 20,
   parameter int SEG_LOG2 = 2,
   localparam int POS_W   = CNT_W - SEG_LOG2
) (
   input  logic [SEG_LOG2-1:0] seg_idx_i,
   input  logic [POS_W-1:0]    seg_pos_i,
   input  logic [POS_W-1:0]    base_i,
   input  logic [SEG_LOG2-1:0] rem_i,
   output logic                level_o
);

   logic [SEG_LOG2-1:0] idx_rev;
   logic                extend;
   logic [POS_W:0]      width;

   // Bit reversal of the sub-period index is wiring only.
   for (genvar b = 0; b < SEG_LOG2; b++) begin : g_rev
      assign idx_rev[b] = seg_idx_i[SEG_LOG2-1-b];
   end

   assign extend  = (idx_rev < rem_i);
   assign width   = {1'b0, base_i} + {{POS_W{1'b0}}, extend};
   assign level_o = ({1'b0, seg_pos_i} < width);

endmodule

// File: rtl/clustered_pwm.sv
// Clustered multi-segment PWM: one frame of 2^CNT_W clocks split into 2^SEG_LOG2 pulses.
module clustered_pwm
   import pwm_cluster_pkg::*;
#(
   parameter int CNT_W    = 20,
   parameter int SEG_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] duty_in,
   output logic             pwm_out,
   output logic             frame_start,
   output logic             subperiod_start
);

   localparam int POS_W   = CNT_W - SEG_LOG2;
   localparam int N_SEG   = seg_count(SEG_LOG2);

   if (SEG_LOG2 < SEG_LOG2_MIN || SEG_LOG2 > SEG_LOG2_MAX) begin : g_bad_seg
      $error("clustered_pwm: SEG_LOG2 must select 4 or 8 sub-periods");
   end
   if (POS_W < POS_W_MIN) begin : g_bad_width
      $error("clustered_pwm: CNT_W too small for the sub-period count");
   end
   if (N_SEG > (1 << (CNT_W - 1))) begin : g_bad_count
      $error("clustered_pwm: more sub-periods than half the frame");
   end

   logic [SEG_LOG2-1:0] seg_idx;
   logic [POS_W-1:0]    seg_pos;
   logic                frame_first;
   logic                frame_last;
   logic                seg_first;
   logic [CNT_W-1:0]    duty_q;
   logic [POS_W-1:0]    base;
   logic [SEG_LOG2-1:0] rem;
   logic                level;

   cpwm_timebase #(
      .CNT_W    (CNT_W),
      .SEG_LOG2 (SEG_LOG2)
   ) u_timebase (
      .clk           (clk),
      .rst           (rst),
      .seg_idx_o     (seg_idx),
      .seg_pos_o     (seg_pos),
      .frame_first_o (frame_first),
      .frame_last_o  (frame_last),
      .seg_first_o   (seg_first)
   );

   cpwm_duty_split #(
      .CNT_W    (CNT_W),
      .SEG_LOG2 (SEG_LOG2)
   ) u_duty (
      .clk      (clk),
      .rst      (rst),
      .load_i   (frame_last),
      .duty_i   (duty_in),
      .duty_q_o (duty_q),
      .base_o   (base),
      .rem_o    (rem)
   );

   cpwm_seg_shaper #(
      .CNT_W    (CNT_W),
      .SEG_LOG2 (SEG_LOG2)
   ) u_shaper (
      .seg_idx_i (seg_idx),
      .seg_pos_i (seg_pos),
      .base_i    (base),
      .rem_i     (rem),
      .level_o   (level)
   );

   // During reset the counter rests at zero; the strobes stay quiet until release.
   assign pwm_out         = level;
   assign frame_start     = frame_first & ~rst;
   assign subperiod_start = seg_first & ~rst;

endmodule

// File: rtl/clustered_pwm_chk.sv
// Property checker attached to clustered_pwm.
module clustered_pwm_chk #(
   parameter int CNT_W    = 20,
   parameter int SEG_LOG2 = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             pwm_out,
   input logic             frame_start,
   input logic             subperiod_start,
   input logic [CNT_W-1:0] duty_q
);

   localparam int POS_W = CNT_W - SEG_LOG2;

   logic [CNT_W:0]   hi_acc;
   logic [CNT_W-1:0] prev_duty;
   logic             seen_frame;
   logic [POS_W-1:0] gap;
   logic             seen_sub;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_acc     <= '0;
         prev_duty  <= '0;
         seen_frame <= 1'b0;
         gap        <= '0;
         seen_sub   <= 1'b0;
      end else begin
         if (frame_start) begin
            hi_acc     <= {{CNT_W{1'b0}}, pwm_out};
            prev_duty  <= duty_q;
            seen_frame <= 1'b1;
         end else begin
            hi_acc <= hi_acc + {{CNT_W{1'b0}}, pwm_out};
         end
         if (subperiod_start) begin
            gap      <= '0;
            seen_sub <= 1'b1;
         end else begin
            gap <= gap + 1'b1;
         end
      end
   end

   AST_FRAME_ON_SUB: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> subperiod_start); // R3

   AST_FRAME_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start); // R2

   AST_SUB_SPACING: assert property (@(posedge clk) disable iff (rst)
      (subperiod_start && seen_sub) |-> (&gap)); // R3

   AST_RISE_AT_SEG: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> subperiod_start); // R4

   AST_FALL_INSIDE_SEG: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_out) |-> (!subperiod_start || frame_start)); // R4

   AST_FRAME_TOTAL: assert property (@(posedge clk) disable iff (rst)
      (frame_start && seen_frame) |-> (hi_acc == {1'b0, prev_duty})); // R6

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !frame_start |-> $stable(duty_q)); // R7

   AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
      (duty_q == '0) |-> !pwm_out); // R8

endmodule

bind clustered_pwm clustered_pwm_chk #(
   .CNT_W    (CNT_W),
   .SEG_LOG2 (SEG_LOG2)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .pwm_out         (pwm_out),
   .frame_start     (frame_start),
   .subperiod_start (subperiod_start),
   .duty_q          (duty_q)
);

// File: tb/sim_clustered_pwm.sv
`timescale 1ns/1ps
module sim_clustered_pwm;

   localparam int W     = 8;
   localparam int K     = 2;
   localparam int N     = 1 << K;
   localparam int FRAME = 1 << W;
   localparam int SEG   = FRAME / N;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] duty_in = '0;
   logic         pwm_out;
   logic         frame_start;
   logic         subperiod_start;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   clustered_pwm #(
      .CNT_W    (W),
      .SEG_LOG2 (K)
   ) u0 (
      .clk             (clk),
      .rst             (rst),
      .duty_in         (duty_in),
      .pwm_out         (pwm_out),
      .frame_start     (frame_start),
      .subperiod_start (subperiod_start)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rev_idx(input int s);
      int r = 0;
      for (int b = 0; b < K; b++) begin
         if (((s >> b) & 1) != 0) r = r | (1 << (K - 1 - b));
      end
      return r;
   endfunction

   function automatic int exp_width(input int d, input int s);
      return (d / N) + ((rev_idx(s) < (d % N)) ? 1 : 0);
   endfunction

   // Called at a sample point holding the first clock of a frame; returns at the next one.
   task automatic measure_frame(input int exp_d, input int nxt);
      int  hi[N];
      int  lead[N];
      bit  cont[N];
      int  total = 0, rises = 0, lows = 0, last_low = -1;
      int  fs_bad = 0, ss_bad = 0;
      bit  prev = 1'b0;
      for (int s = 0; s < N; s++) begin
         hi[s] = 0; lead[s] = 0; cont[s] = 1'b1;
      end
      for (int c = 0; c < FRAME; c++) begin
         int s, p;
         if (c > 0) @(negedge clk);
         s = c / SEG;
         p = c % SEG;
         if (frame_start !== (c == 0)) fs_bad++;
         if (subperiod_start !== (p == 0)) ss_bad++;
         if (pwm_out === 1'b1) begin
            hi[s]++;
            total++;
            if (cont[s]) lead[s]++;
            if (!prev) rises++;
            prev = 1'b1;
         end else begin
            cont[s] = 1'b0;
            lows++;
            last_low = c;
            prev = 1'b0;
         end
         if (c == 0) duty_in = W'(~nxt);
         if (c == FRAME / 2) duty_in = W'(nxt);
      end
      @(negedge clk);
      check(fs_bad == 0, "R2 frame_start placement", fs_bad, 0);
      check(ss_bad == 0, "R3 subperiod_start placement", ss_bad, 0);
      check(total == exp_d, "R6 R7 frame high total", total, exp_d);
      for (int s = 0; s < N; s++) begin
         check(hi[s] == exp_width(exp_d, s), "R5 sub-period width", hi[s], exp_width(exp_d, s));
         check(lead[s] == hi[s], "R4 pulse contiguous from sub-period start", lead[s], hi[s]);
      end
      if (exp_d == 0) begin
         check(total == 0 && rises == 0, "R8 zero duty stays low", total, 0);
      end
      if (exp_d == FRAME - 1) begin
         check(lows == 1 && last_low == FRAME - 1, "R9 full duty single low clock", last_low, FRAME - 1);
      end
      if (exp_d >= N && exp_d < FRAME - N) begin
         check(rises == N, "R10 rising edge count", rises, N);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      int prev_d;
      rst = 1'b1;
      duty_in = W'(100);
      repeat (4) @(negedge clk);
      check(pwm_out === 1'b0, "R1 output low in reset", int'(pwm_out), 0);
      check(frame_start === 1'b0, "R1 frame_start quiet in reset", int'(frame_start), 0);
      check(subperiod_start === 1'b0, "R1 subperiod_start quiet in reset", int'(subperiod_start), 0);
      rst = 1'b0;
      #1;
      check(frame_start === 1'b1, "R1 frame_start after release", int'(frame_start), 1);
      // First frame after reset is low although duty_in holds 100.
      measure_frame(0, 0);
      prev_d = 0;
      for (int d = 1; d < FRAME; d++) begin
         measure_frame(prev_d, d);
         prev_d = d;
      end
      measure_frame(prev_d, 0);
      measure_frame(0, FRAME - 1);
      measure_frame(FRAME - 1, 1);
      measure_frame(1, 2);
      measure_frame(2, 0);

      // Reset in the middle of a frame.
      duty_in = W'(200);
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(pwm_out === 1'b0, "R1 output low after mid-frame reset", int'(pwm_out), 0);
      check(subperiod_start === 1'b0, "R1 strobe quiet in mid-frame reset", int'(subperiod_start), 0);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check(frame_start === 1'b1, "R1 frame_start after second release", int'(frame_start), 1);
      measure_frame(0, 50);
      measure_frame(50, 50);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule